// File: doc/BRIEF.md
# Host Bus Address Decode Unit

This block is the front end of a slave device that sits on an asynchronous host bus. When the bus address strobe goes from low back to high, it captures the address, the DMA-address qualifier and the four active-low lane enables. From these latched values it produces four results:

- an active-low select when the upper address bits equal a programmable base address;
- a four-bit byte-lane mask;
- a two-bit access-size code;
- the low register offset inside the decoded window.

A separate active-low chip select for the queue data register bypasses the local decode and forces a full-width access. A parameter chooses between a 32-bit and a 16-bit host bus.

The block passes no data stream. Every pin is a plain control or status signal, so there is no valid/ready handshake and no back-pressure. The strobe and the chip select are sampled on the block clock. The strobe must stay low for at least one clock cycle, and the latched inputs must be stable on the clock edge that samples the strobe high again. The base register is written through a synchronous write port.

Top module: `hbus_decode_top`

## Requirements
- R1: On the clock edge where `strobe_n` is seen high after having been low on the previous edge, `addr_i`, `dma_addr_i` and `lane_en_n_i` are latched. At all other times the latched values hold, and so do all outputs that depend on them. `reg_off_o` shows latched address bits [3:1].
- R2: `sel_n_o` is low exactly when the latched `dma_addr_i` is 0, latched address bits [15:4] equal the base register, and the data-register chip select is not in force.
- R3: While the latched `dma_addr_i` is 1, `sel_n_o` stays high whatever the address and base.
- R4: The base register resets to 0. It takes `base_wdata_i` on a clock edge where `base_we_i` is 1, and the compare uses the new value from the next cycle.
- R5: Lane decode, with mask bit i standing for byte lane i. One enable low gives size 00 (byte) and only that mask bit set. Lanes 0+1 low gives size 01 (half) and mask 0011. Lanes 2+3 low gives size 01 and mask 1100. All four low gives size 10 (word) and mask 1111.
- R6: Any other enable pattern, including all enables high, gives size 11 (invalid) and mask 0000. This is also the state after reset.
- R7: In 32-bit mode, while `qdata_cs_n_i` is low, the result is mask 1111, size 10, `qdata_sel_o` 1 and `sel_n_o` 1, whatever the enables and address. `qdata_sel_o` is 0 otherwise.
- R8: In 16-bit mode, lane enables 3 and 2 and `qdata_cs_n_i` are ignored. Only byte 0, byte 1 or the lower half (mask 0011, including the all-low case) are valid, and `qdata_sel_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, clears all latched state |
| strobe_n | input | 1 | Active-low address strobe; its rising edge latches |
| addr_i | input | 15 | Host address bits [15:1] |
| dma_addr_i | input | 1 | High marks a DMA memory address; decoding only while low |
| lane_en_n_i | input | 4 | Active-low byte lane enables, bit i for lane i |
| qdata_cs_n_i | input | 1 | Active-low queue data register chip select (32-bit mode) |
| base_we_i | input | 1 | Base register write enable |
| base_wdata_i | input | 12 | Base register write data (compares with address [15:4]) |
| sel_n_o | output | 1 | Active-low local device select |
| lane_mask_o | output | 4 | Active byte lanes |
| size_o | output | 2 | 00 byte, 01 half, 10 word, 11 invalid |
| qdata_sel_o | output | 1 | Data register access forced by chip select |
| reg_off_o | output | 3 | Latched address bits [3:1] |

## Verification
Random addresses are drawn so that about half of them hit the base window. Mixed with the DMA qualifier, this separates the address-compare term from the DMA-blocking term of the select. Lane enables are drawn from all sixteen codes, which separates the seven legal shapes from the non-contiguous and empty ones. A 16-bit instance is run on the same stimulus, which shows that the upper enables and the chip select are dropped there. Directed cases cover:
- the reset state;
- moving the inputs without a strobe edge, to show the latch holds;
- a base rewrite moving the window;
- the chip select overriding an invalid enable pattern and a matching address.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_BAD  = 2'b11
  } size_e;

  typedef struct packed {
    logic [3:0] mask;
    size_e      size;
  } lane_t;
endpackage

// File: rtl/hbd_strobe_latch.sv
module hbd_strobe_latch #(
  parameter int ADDR_HI = 15,
  parameter int ADDR_LO = 1,
  parameter int NLANE   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   strobe_n,
  input  logic [ADDR_HI:ADDR_LO] addr_i,
  input  logic                   dma_addr_i,
  input  logic [NLANE-1:0]       lane_en_n_i,
  output logic [ADDR_HI:ADDR_LO] addr_q,
  output logic                   dma_q,
  output logic [NLANE-1:0]       lane_en_n_q
);
  logic strobe_prev;
  logic capture;

  // release of the strobe: low on the last edge, high now
  assign capture = !strobe_prev && strobe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_prev <= 1'b1;
      addr_q      <= '0;
      dma_q       <= 1'b1;
      lane_en_n_q <= '1;
    end else begin
      strobe_prev <= strobe_n;
      if (capture) begin
        addr_q      <= addr_i;
        dma_q       <= dma_addr_i;
        lane_en_n_q <= lane_en_n_i;
      end
    end
  end

  AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> ($stable(addr_q) && $stable(dma_q) && $stable(lane_en_n_q))); // R1
endmodule

// File: rtl/hbd_base_reg.sv
module hbd_base_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] base_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else if (we_i) base_q <= wdata_i;
  end

  AST_BASE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (base_q == $past(wdata_i))); // R4
  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(base_q)); // R4
endmodule

// File: rtl/hbd_lane_decode.sv
module hbd_lane_decode
  import hbd_pkg::*;
#(
  parameter bit BUS32 = 1'b1
) (
  input  logic [3:0] lane_en_n_i,
  input  logic       qdata_cs_n_i,
  output lane_t      lane_o,
  output logic       qdata_sel_o
);
  logic [3:0] en_eff;
  logic       cs_act;
  lane_t      dec;

  generate
    if (BUS32) begin : g_wide
      assign en_eff = ~lane_en_n_i;
      assign cs_act = ~qdata_cs_n_i;
    end else begin : g_narrow
      // upper lanes and data chip select are not wired on a 16-bit bus
      assign en_eff = {~lane_en_n_i[3:2] & 2'b00, ~lane_en_n_i[1:0]};
      assign cs_act = ~qdata_cs_n_i & 1'b0;
    end
  endgenerate

  always_comb begin
    dec = '{mask: 4'b0000, size: SZ_BAD};
    unique case (en_eff)
      4'b0001, 4'b0010,
      4'b0100, 4'b1000: dec = '{mask: en_eff, size: SZ_BYTE};
      4'b0011, 4'b1100: dec = '{mask: en_eff, size: SZ_HALF};
      4'b1111:          dec = '{mask: en_eff, size: SZ_WORD};
      default:          dec = '{mask: 4'b0000, size: SZ_BAD};
    endcase
  end

  assign lane_o      = cs_act ? '{mask: 4'b1111, size: SZ_WORD} : dec;
  assign qdata_sel_o = cs_act;
endmodule

// File: rtl/hbus_decode_top.sv
module hbus_decode_top
  import hbd_pkg::*;
#(
  parameter bit BUS32   = 1'b1,
  parameter int ADDR_HI = 15,
  parameter int DEC_LO  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  strobe_n,
  input  logic [ADDR_HI-1:0]    addr_i,
  input  logic                  dma_addr_i,
  input  logic [3:0]            lane_en_n_i,
  input  logic                  qdata_cs_n_i,
  input  logic                  base_we_i,
  input  logic [ADDR_HI-DEC_LO:0] base_wdata_i,
  output logic                  sel_n_o,
  output logic [3:0]            lane_mask_o,
  output logic [1:0]            size_o,
  output logic                  qdata_sel_o,
  output logic [DEC_LO-2:0]     reg_off_o
);
  localparam int BASE_W = ADDR_HI - DEC_LO + 1;

  logic [ADDR_HI:1]   addr_q;
  logic               dma_q;
  logic [3:0]         lane_en_n_q;
  logic [BASE_W-1:0]  base_q;
  lane_t              lane;
  logic               hit;

  hbd_strobe_latch #(.ADDR_HI(ADDR_HI), .ADDR_LO(1), .NLANE(4)) u_latch (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe_n    (strobe_n),
    .addr_i      (addr_i),
    .dma_addr_i  (dma_addr_i),
    .lane_en_n_i (lane_en_n_i),
    .addr_q      (addr_q),
    .dma_q       (dma_q),
    .lane_en_n_q (lane_en_n_q)
  );

  hbd_base_reg #(.W(BASE_W)) u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (base_we_i),
    .wdata_i (base_wdata_i),
    .base_q  (base_q)
  );

  hbd_lane_decode #(.BUS32(BUS32)) u_lane (
    .lane_en_n_i  (lane_en_n_q),
    .qdata_cs_n_i (qdata_cs_n_i),
    .lane_o       (lane),
    .qdata_sel_o  (qdata_sel_o)
  );

  assign hit         = !dma_q && (addr_q[ADDR_HI:DEC_LO] == base_q);
  assign sel_n_o     = !(hit && !qdata_sel_o);
  assign lane_mask_o = lane.mask;
  assign size_o      = lane.size;
  assign reg_off_o   = addr_q[DEC_LO-1:1];

  AST_DMA_BLOCKS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    dma_q |-> sel_n_o); // R3
  AST_QDATA_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    qdata_sel_o |-> (sel_n_o && lane_mask_o == 4'hF && size_o == 2'b10)); // R7
  AST_BAD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (size_o == 2'b11) |-> (lane_mask_o == 4'h0)); // R6
  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (size_o == 2'b00) |-> ($countones(lane_mask_o) == 1)); // R5
  AST_HALF_TWO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (size_o == 2'b01) |-> (lane_mask_o == 4'h3 || lane_mask_o == 4'hC)); // R5
  AST_NARROW_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
    !BUS32 |-> (lane_mask_o[3:2] == 2'b00 && !qdata_sel_o)); // R8
endmodule

// File: tb/hbus_decode_top_tb.sv
`timescale 1ns/1ps
module hbus_decode_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strobe_n = 1'b1;
  logic [14:0] addr = '0;
  logic        dma = 1'b1;
  logic [3:0]  be_n = 4'hF;
  logic        cs_n = 1'b1;
  logic        we = 1'b0;
  logic [11:0] wdata = '0;

  logic       sel_n_w, qsel_w, sel_n_n, qsel_n;
  logic [3:0] mask_w, mask_n;
  logic [1:0] size_w, size_n;
  logic [2:0] off_w, off_n;

  int tests = 0;
  int fails = 0;
  logic [11:0] base_m = '0;
  logic [14:0] addr_m = '0;
  logic        dma_m = 1'b1;
  logic [3:0]  be_m = 4'hF;

  always #10 clk = ~clk;

  hbus_decode_top #(.BUS32(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .addr_i(addr),
    .dma_addr_i(dma), .lane_en_n_i(be_n), .qdata_cs_n_i(cs_n),
    .base_we_i(we), .base_wdata_i(wdata), .sel_n_o(sel_n_w),
    .lane_mask_o(mask_w), .size_o(size_w), .qdata_sel_o(qsel_w),
    .reg_off_o(off_w));

  hbus_decode_top #(.BUS32(1'b0)) u_dut16 (
    .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .addr_i(addr),
    .dma_addr_i(dma), .lane_en_n_i(be_n), .qdata_cs_n_i(cs_n),
    .base_we_i(we), .base_wdata_i(wdata), .sel_n_o(sel_n_n),
    .lane_mask_o(mask_n), .size_o(size_n), .qdata_sel_o(qsel_n),
    .reg_off_o(off_n));

  function automatic logic [5:0] exp_lane(input logic [3:0] en_n, input logic csn,
                                          input bit wide);
    logic [3:0] m;
    if (wide && !csn) return {4'hF, 2'b10};
    m = ~en_n;
    if (!wide) m[3:2] = 2'b00;
    case (m)
      4'h1, 4'h2, 4'h4, 4'h8: return {m, 2'b00};
      4'h3, 4'hC:             return {m, 2'b01};
      4'hF:                   return {m, 2'b10};
      default:                return {4'h0, 2'b11};
    endcase
  endfunction

  function automatic logic exp_sel_n(input bit wide, input logic csn);
    if (wide && !csn) return 1'b1;
    return !(!dma_m && addr_m[14:3] == base_m);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    logic [5:0] lw, ln;
    lw = exp_lane(be_m, cs_n, 1'b1);
    ln = exp_lane(be_m, cs_n, 1'b0);
    chk({req, " R5/R6/R7 wide lanes"}, {mask_w, size_w}, lw);
    chk({req, " R8 narrow lanes"}, {mask_n, size_n}, ln);
    chk({req, " R2/R3/R7 wide sel"}, sel_n_w, exp_sel_n(1'b1, cs_n));
    chk({req, " R2/R3 narrow sel"}, sel_n_n, exp_sel_n(1'b0, cs_n));
    chk({req, " R7/R8 qdata sel"}, {qsel_w, qsel_n}, {~cs_n, 1'b0});
    chk({req, " R1 offset"}, {off_w, off_n}, {addr_m[2:0], addr_m[2:0]});
  endtask

  task automatic bus_cycle(input logic [14:0] a, input logic d, input logic [3:0] b,
                           input logic c);
    @(negedge clk);
    addr = a; dma = d; be_n = b; cs_n = c; strobe_n = 1'b0;
    @(negedge clk);
    strobe_n = 1'b1;
    @(negedge clk);
    addr_m = a; dma_m = d; be_m = b;
  endtask

  task automatic write_base(input logic [11:0] v);
    @(negedge clk);
    we = 1'b1; wdata = v;
    @(negedge clk);
    we = 1'b0;
    base_m = v;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state: invalid, no lanes, deselected (R6, R4)
    check_all("reset R6");

    // R4: base 0 matches address window 0 with dma low
    bus_cycle(15'h0005, 1'b0, 4'b0000, 1'b1);
    check_all("base0 R4");
    // R1: move inputs without strobe edge, outputs hold
    @(negedge clk);
    addr = 15'h7FFF; dma = 1'b1; be_n = 4'b0101;
    repeat (3) @(negedge clk);
    check_all("hold R1");
    // R3: dma high blocks select
    bus_cycle(15'h0002, 1'b1, 4'b1100, 1'b1);
    check_all("dma R3");
    // R4: new base moves the window
    write_base(12'hA5C);
    bus_cycle({12'hA5C, 3'd6}, 1'b0, 4'b0011, 1'b1);
    check_all("rebase R4 R2");
    bus_cycle({12'hA5D, 3'd6}, 1'b0, 4'b1110, 1'b1);
    check_all("miss R2");
    // R7: chip select overrides invalid pattern and matching address
    bus_cycle({12'hA5C, 3'd1}, 1'b0, 4'b1010, 1'b0);
    check_all("qdata R7");
    // R6: all enables high
    bus_cycle({12'hA5C, 3'd1}, 1'b0, 4'b1111, 1'b1);
    check_all("empty R6");
    // R8: all low in narrow mode is lower half
    bus_cycle({12'hA5C, 3'd0}, 1'b0, 4'b0000, 1'b1);
    check_all("narrow R8");

    for (int i = 0; i < 400; i++) begin
      logic [11:0] hi;
      if (($urandom % 16) == 0) write_base(12'($urandom));
      hi = (($urandom % 2) == 0) ? base_m : 12'($urandom);
      bus_cycle({hi, 3'($urandom)}, 1'(($urandom % 3) == 0), 4'($urandom),
                1'(($urandom % 5) != 0));
      check_all("random R5");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule